// File: doc/BRIEF.md
# Hardware Loop Status Controller

This block keeps the loop bookkeeping for a 16-bit DSP program sequencer. It holds the loop-active flag in bit 15 of the status register and the enclosing-loop flag in bit 15 of the mode register. It also holds a two-entry hardware stack of loop-top addresses, and the loop end address and remaining-pass count.

A DO-loop start pushes the loop-top address, loads the end address and the count, and saves the old loop-active flag into the enclosing-loop flag. While the loop-active flag is high, each valid fetch whose address equals the end address uses up one pass. If more passes remain, the block raises `loop_back` for one cycle. The sequencer then jumps to `hws_top`. On the last pass, the block pops the stack and restores the loop-active flag from the enclosing-loop flag.

Software moves to and from the stack register use the same save and restore of the two flags. The block also decodes the two interrupt-mask bits into per-level enables. It loads the operating-mode field from the mode pins during reset.

Top module: `loop_status_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears both flags, empties the stack and clears `stack_err` and `loop_back`. The status low bits become 0x300, so `sr_rdata` reads 0x0300. `omr_rdata` reads the mode pins in its low `MODE_W` bits and zero elsewhere.
- R2: A `do_start` pushes `do_top` and loads `do_end` and `do_count`. It copies the loop-active flag (status bit 15) into the enclosing-loop flag (mode bit 15), then sets the loop-active flag.
- R3: A loop-end hit needs `fetch_vld`, a set loop-active flag and `fetch_addr` equal to the loaded end address. If the remaining count is above 1, the hit decrements it and drives `loop_back` high in the cycle after the hit, for one cycle only.
- R4: A loop-end hit with a remaining count of 1 (or 0) ends the loop. It pops the stack, copies the enclosing-loop flag into the loop-active flag, clears the enclosing-loop flag, and leaves `loop_back` low.
- R5: While the loop-active flag is clear, a fetch at the end address causes no hit: no `loop_back`, no pop and no flag change.
- R6: `hws_wr` pushes `hws_wdata`, copies the loop-active flag into the enclosing-loop flag, and then sets the loop-active flag.
- R7: `hws_top` shows the top entry (zero when empty) before a read. `hws_rd` then pops it, copies the enclosing-loop flag into the loop-active flag, and clears the enclosing-loop flag.
- R8: `irq_entry` and `rep_active` leave both flags and the stack unchanged.
- R9: `sr_wr` loads status bit 15 (loop-active) and bits 9:0 from `sr_wdata`. Status bits 14:10 always read zero.
- R10: `omr_wr` loads all 16 mode-register bits from `omr_wdata`. Bit 15 is the enclosing-loop flag.
- R11: The mask field is status bits 9:8. Code 01 sets `ipl0_en` and `ipl1_en`. Code 11 sets only `ipl1_en`. The reserved codes 00 and 10 clear both enables.
- R12: A push onto two stored entries, or a pop from an empty stack, sets `stack_err` and leaves the entries unchanged. The flags still update. `stack_err` stays set until reset.
- R13: Only one event acts per cycle, in this order: `do_start`, `hws_wr`, `hws_rd`, loop-end hit, `sr_wr`, `omr_wr`. Any lower-ranked request in the same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pins | input | MODE_W | Operating mode sampled during reset |
| do_start | input | 1 | DO-loop start pulse |
| do_top | input | ADDR_W | Loop-top address pushed at start |
| do_end | input | ADDR_W | Loop end address |
| do_count | input | CNT_W | Number of passes |
| fetch_vld | input | 1 | A fetch happens this cycle |
| fetch_addr | input | ADDR_W | Current fetch address |
| hws_wr | input | 1 | Move into the stack register |
| hws_wdata | input | ADDR_W | Value pushed by a move |
| hws_rd | input | 1 | Read (move or test) of the stack register |
| sr_wr | input | 1 | Status register write strobe |
| sr_wdata | input | 16 | Status register write value |
| omr_wr | input | 1 | Mode register write strobe |
| omr_wdata | input | 16 | Mode register write value |
| irq_entry | input | 1 | Interrupt service entry pulse |
| rep_active | input | 1 | Single-instruction repeat in progress |
| loop_back | output | 1 | Jump to loop top, one cycle |
| hws_top | output | ADDR_W | Top stack entry, zero when empty |
| hws_level | output | $clog2(STACK_DEPTH+1) | Number of stored entries |
| stack_err | output | 1 | Sticky overflow/underflow flag |
| sr_rdata | output | 16 | Status register read value |
| omr_rdata | output | 16 | Mode register read value |
| ipl0_en | output | 1 | Level-0 requests permitted |
| ipl1_en | output | 1 | Level-1 requests permitted |

## Verification
The hardest state to reach is a nested loop whose inner exit must restore a set loop-active flag from the enclosing-loop flag. This differs from the single-loop case, where the restored value is zero. The bench starts an outer loop and then an inner loop, so that both flags are set and two entries are stacked. It then sends two fetches at the inner end address. Next it reads the stack register to unwind the outer level. Overflow and underflow are reached the same way: three moves into the stack, then three reads.

// File: rtl/lsc_pkg.sv
// Shared definitions for the loop status controller.
// Assumes 16-bit status and mode registers with the flag bit at 15.
package lsc_pkg;
    localparam int REG_W     = 16;
    localparam int FLAG_BIT  = 15;
    localparam int SR_KEEP_W = 10;

    localparam logic [1:0] MASK_BOTH_OPEN = 2'b01;
    localparam logic [1:0] MASK_LOW_SHUT  = 2'b11;

    // The single event that acts in a cycle, after priority selection
    typedef enum logic [2:0] {
        EV_IDLE,
        EV_DO_PUSH,
        EV_MOVE_PUSH,
        EV_MOVE_POP,
        EV_LOOP_AGAIN,
        EV_LOOP_EXIT,
        EV_SR_LOAD,
        EV_OMR_LOAD
    } lsc_event_e;
endpackage

// File: rtl/lsc_hw_stack.sv
// Small LIFO of loop-top addresses.
// Pushing when full or popping when empty sets a sticky error and keeps
// the entries. Assumes push and pop are never requested together.
module lsc_hw_stack #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 2,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] top,
    output logic [LVL_W-1:0] level,
    output logic             err
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic full, empty;

    assign full  = (level == LVL_W'(DEPTH));
    assign empty = (level == '0);

    // Fill level and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            err   <= 1'b0;
        end else if (push) begin
            if (full) err <= 1'b1;
            else      level <= level + 1'b1;
        end else if (pop) begin
            if (empty) err <= 1'b1;
            else       level <= level - 1'b1;
        end
    end

    // One storage slot per entry, written when it is the next free one
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && level == LVL_W'(i))
                mem[i] <= push_data;
        end
    end

    // Select the most recent entry, zero when empty
    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++)
            if (level == LVL_W'(i + 1)) top = mem[i];
    end
endmodule

// File: rtl/lsc_flag_pair.sv
// Loop-active flag and enclosing-loop flag.
// A push saves the active flag into the enclosing flag and sets the active
// flag. A pop restores the active flag and clears the enclosing flag.
module lsc_flag_pair
    import lsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lsc_event_e ev,
    input  logic       sr_lf_in,
    input  logic       omr_nl_in,
    output logic       lf,
    output logic       nl
);
    // Update both flags from the selected event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lf <= 1'b0;
            nl <= 1'b0;
        end else begin
            case (ev)
                EV_DO_PUSH, EV_MOVE_PUSH: begin
                    nl <= lf;
                    lf <= 1'b1;
                end
                EV_MOVE_POP, EV_LOOP_EXIT: begin
                    lf <= nl;
                    nl <= 1'b0;
                end
                EV_SR_LOAD:  lf <= sr_lf_in;
                EV_OMR_LOAD: nl <= omr_nl_in;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lsc_loop_match.sv
// Loop end address and pass count, plus the end-of-loop comparator.
// The comparison is gated by the loop-active flag. A count of 0 or 1
// counts as the last pass.
module lsc_loop_match #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_end,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              lf,
    input  logic              again,
    input  logic              finish,
    output logic              end_hit,
    output logic              last_pass,
    output logic              loop_back
);
    logic [ADDR_W-1:0] la;
    logic [CNT_W-1:0]  lc;

    assign end_hit   = fetch_vld && lf && (fetch_addr == la);
    assign last_pass = (lc <= CNT_W'(1));

    // Load on loop start, count down on every consumed pass
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la        <= '0;
            lc        <= '0;
            loop_back <= 1'b0;
        end else begin
            loop_back <= again;
            if (load) begin
                la <= load_end;
                lc <= load_cnt;
            end else if ((again || finish) && lc != '0) begin
                lc <= lc - 1'b1;
            end
        end
    end
endmodule

// File: rtl/loop_status_ctl.sv
// Top of the hardware loop status controller.
// Picks one event per cycle by fixed priority and drives the flag pair,
// the stack and the loop comparator. Keeps the status and mode register
// bits. Interrupt entry and repeat mode have no effect here by design.
module loop_status_ctl
    import lsc_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int CNT_W       = 16,
    parameter int STACK_DEPTH = 2,
    parameter int MODE_W      = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [MODE_W-1:0]                mode_pins,
    input  logic                             do_start,
    input  logic [ADDR_W-1:0]                do_top,
    input  logic [ADDR_W-1:0]                do_end,
    input  logic [CNT_W-1:0]                 do_count,
    input  logic                             fetch_vld,
    input  logic [ADDR_W-1:0]                fetch_addr,
    input  logic                             hws_wr,
    input  logic [ADDR_W-1:0]                hws_wdata,
    input  logic                             hws_rd,
    input  logic                             sr_wr,
    input  logic [15:0]                      sr_wdata,
    input  logic                             omr_wr,
    input  logic [15:0]                      omr_wdata,
    input  logic                             irq_entry,
    input  logic                             rep_active,
    output logic                             loop_back,
    output logic [ADDR_W-1:0]                hws_top,
    output logic [$clog2(STACK_DEPTH+1)-1:0] hws_level,
    output logic                             stack_err,
    output logic [15:0]                      sr_rdata,
    output logic [15:0]                      omr_rdata,
    output logic                             ipl0_en,
    output logic                             ipl1_en
);
    localparam int RSV_W = FLAG_BIT - SR_KEEP_W;

    lsc_event_e           ev;
    logic                 lf, nl, end_hit, last_pass;
    logic [SR_KEEP_W-1:0] sr_low;
    logic [FLAG_BIT-1:0]  omr_rest;
    logic [1:0]           mask;
    logic                 unused_inputs;

    assign unused_inputs = ^{irq_entry, rep_active, sr_wdata[FLAG_BIT-1:SR_KEEP_W]};

    // Fixed-priority selection of the one event acting this cycle
    always_comb begin
        if (do_start)     ev = EV_DO_PUSH;
        else if (hws_wr)  ev = EV_MOVE_PUSH;
        else if (hws_rd)  ev = EV_MOVE_POP;
        else if (end_hit) ev = last_pass ? EV_LOOP_EXIT : EV_LOOP_AGAIN;
        else if (sr_wr)   ev = EV_SR_LOAD;
        else if (omr_wr)  ev = EV_OMR_LOAD;
        else              ev = EV_IDLE;
    end

    lsc_flag_pair u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .sr_lf_in  (sr_wdata[FLAG_BIT]),
        .omr_nl_in (omr_wdata[FLAG_BIT]),
        .lf        (lf),
        .nl        (nl)
    );

    lsc_hw_stack #(.WIDTH(ADDR_W), .DEPTH(STACK_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ev == EV_DO_PUSH || ev == EV_MOVE_PUSH),
        .pop       (ev == EV_MOVE_POP || ev == EV_LOOP_EXIT),
        .push_data (do_start ? do_top : hws_wdata),
        .top       (hws_top),
        .level     (hws_level),
        .err       (stack_err)
    );

    lsc_loop_match #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ev == EV_DO_PUSH),
        .load_end   (do_end),
        .load_cnt   (do_count),
        .fetch_vld  (fetch_vld),
        .fetch_addr (fetch_addr),
        .lf         (lf),
        .again      (ev == EV_LOOP_AGAIN),
        .finish     (ev == EV_LOOP_EXIT),
        .end_hit    (end_hit),
        .last_pass  (last_pass),
        .loop_back  (loop_back)
    );

    // Status low bits and mode bits other than the enclosing-loop flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_low                   <= SR_KEEP_W'(10'h300);
            omr_rest                 <= '0;
            omr_rest[MODE_W-1:0]     <= mode_pins;
        end else if (ev == EV_SR_LOAD) begin
            sr_low <= sr_wdata[SR_KEEP_W-1:0];
        end else if (ev == EV_OMR_LOAD) begin
            omr_rest <= omr_wdata[FLAG_BIT-1:0];
        end
    end

    assign sr_rdata  = {lf, {RSV_W{1'b0}}, sr_low};
    assign omr_rdata = {nl, omr_rest};

    // Interrupt mask decode; reserved codes permit nothing
    assign mask    = sr_low[9:8];
    assign ipl0_en = (mask == MASK_BOTH_OPEN);
    assign ipl1_en = (mask == MASK_BOTH_OPEN) || (mask == MASK_LOW_SHUT);
endmodule

// File: rtl/loop_status_chk.sv
// Property checker for loop_status_ctl, bound to every instance.
// It watches only the ports of the top module.
module loop_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        do_start,
    input logic        hws_wr,
    input logic        hws_rd,
    input logic        sr_wr,
    input logic        omr_wr,
    input logic        fetch_vld,
    input logic        loop_back,
    input logic        stack_err,
    input logic [15:0] sr_rdata,
    input logic [15:0] omr_rdata,
    input logic        ipl0_en,
    input logic        ipl1_en
);
    a_r2_do_saves_flag: assert property (@(posedge clk) disable iff (!rst_n)
        do_start |=> sr_rdata[15] && (omr_rdata[15] == $past(sr_rdata[15])));

    a_r3_back_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        loop_back |-> $past(fetch_vld) && $past(sr_rdata[15]));

    a_r6_move_push: assert property (@(posedge clk) disable iff (!rst_n)
        (hws_wr && !do_start) |=> sr_rdata[15] && (omr_rdata[15] == $past(sr_rdata[15])));

    a_r7_move_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (hws_rd && !hws_wr && !do_start) |=> (sr_rdata[15] == $past(omr_rdata[15])) && !omr_rdata[15]);

    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_start && !hws_wr && !hws_rd && !sr_wr && !omr_wr && !fetch_vld)
        |=> $stable(sr_rdata[15]) && $stable(omr_rdata[15]));

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sr_rdata[14:10] == 5'd0);

    a_r11_low_shut: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_rdata[9:8] == 2'b11) |-> (ipl1_en && !ipl0_en));

    a_r11_low_open: assert property (@(posedge clk) disable iff (!rst_n)
        ipl0_en |-> (sr_rdata[9:8] == 2'b01) && ipl1_en);

    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);
endmodule

bind loop_status_ctl loop_status_chk u_chk (.*);

// File: tb/tb_loop_status_ctl.sv
`timescale 1ns/1ps
module tb_loop_status_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_pins = '0;
    logic        do_start = 0, fetch_vld = 0, hws_wr = 0, hws_rd = 0;
    logic        sr_wr = 0, omr_wr = 0, irq_entry = 0, rep_active = 0;
    logic [15:0] do_top = '0, do_end = '0, do_count = '0, fetch_addr = '0;
    logic [15:0] hws_wdata = '0, sr_wdata = '0, omr_wdata = '0;
    logic        loop_back, stack_err, ipl0_en, ipl1_en;
    logic [15:0] hws_top, sr_rdata, omr_rdata;
    logic [1:0]  hws_level;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    loop_status_ctl dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clk1();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        do_start = 0; fetch_vld = 0; hws_wr = 0; hws_rd = 0;
        sr_wr = 0; omr_wr = 0; irq_entry = 0; rep_active = 0;
    endtask

    task automatic do_reset(input logic [1:0] m);
        idle();
        rst_n = 0; mode_pins = m;
        clk1(); clk1();
        rst_n = 1;
    endtask

    task automatic start_loop(input logic [15:0] t, input logic [15:0] e, input logic [15:0] c);
        do_start = 1; do_top = t; do_end = e; do_count = c;
        clk1(); idle();
    endtask

    task automatic fetch(input logic [15:0] a);
        fetch_vld = 1; fetch_addr = a;
        clk1(); idle();
    endtask

    task automatic t_reset();
        do_reset(2'b10);
        chk("R1 sr", 32'(sr_rdata), 32'h0300);
        chk("R1 omr", 32'(omr_rdata), 32'h0002);
        chk("R1 level", 32'(hws_level), 0);
        chk("R1 top", 32'(hws_top), 0);
        chk("R1 err/back", 32'({stack_err, loop_back}), 0);
        chk("R11 reset mask", 32'({ipl0_en, ipl1_en}), 32'b01);
    endtask

    task automatic t_single_loop();
        do_reset(2'b00);
        start_loop(16'h0100, 16'h0103, 16'd3);
        chk("R2 lf set", 32'(sr_rdata), 32'h8300);
        chk("R2 nl saved", 32'(omr_rdata[15]), 0);
        chk("R2 top", 32'(hws_top), 32'h0100);
        fetch(16'h0102);
        chk("R3 no hit off end", 32'(loop_back), 0);
        fetch(16'h0103);
        chk("R3 back pass1", 32'(loop_back), 1);
        clk1();
        chk("R3 back one cycle", 32'(loop_back), 0);
        fetch(16'h0103);
        chk("R3 back pass2", 32'(loop_back), 1);
        fetch(16'h0103);
        chk("R4 no back on exit", 32'(loop_back), 0);
        chk("R4 lf restored", 32'(sr_rdata[15]), 0);
        chk("R4 popped", 32'(hws_level), 0);
        fetch(16'h0103);
        chk("R5 gated", 32'({loop_back, hws_level, stack_err}), 0);
    endtask

    task automatic t_nested();
        do_reset(2'b00);
        start_loop(16'h0010, 16'h0020, 16'd1);
        start_loop(16'h0012, 16'h0018, 16'd2);
        chk("R2 nested flags", 32'({sr_rdata[15], omr_rdata[15]}), 32'b11);
        chk("R2 nested level", 32'(hws_level), 2);
        fetch(16'h0018);
        chk("R3 inner back", 32'(loop_back), 1);
        fetch(16'h0018);
        chk("R4 inner exit flags", 32'({sr_rdata[15], omr_rdata[15]}), 32'b10);
        chk("R4 outer top", 32'(hws_top), 32'h0010);
        hws_rd = 1;
        chk("R7 top before read", 32'(hws_top), 32'h0010);
        clk1(); idle();
        chk("R7 flags after read", 32'({sr_rdata[15], omr_rdata[15]}), 0);
        chk("R7 empty", 32'({hws_level, stack_err}), 0);
    endtask

    task automatic t_move_stack();
        do_reset(2'b00);
        hws_wr = 1; hws_wdata = 16'hAAAA; clk1(); idle();
        chk("R6 push1 flags", 32'({sr_rdata[15], omr_rdata[15]}), 32'b10);
        chk("R6 push1 top", 32'(hws_top), 32'hAAAA);
        hws_wr = 1; hws_wdata = 16'h5555; clk1(); idle();
        chk("R6 push2 flags", 32'({sr_rdata[15], omr_rdata[15]}), 32'b11);
        hws_wr = 1; hws_wdata = 16'h1234; clk1(); idle();
        chk("R12 overflow err", 32'(stack_err), 1);
        chk("R12 overflow kept", 32'({hws_level, hws_top}), {2'd2, 16'h5555});
        hws_rd = 1; clk1(); idle();
        chk("R7 pop flags", 32'({sr_rdata[15], omr_rdata[15]}), 32'b10);
        chk("R7 pop top", 32'(hws_top), 32'hAAAA);
        hws_rd = 1; clk1(); idle();
        chk("R7 pop2 flags", 32'({sr_rdata[15], omr_rdata[15]}), 0);
        hws_rd = 1; clk1(); idle();
        chk("R12 underflow", 32'({stack_err, hws_level}), 32'b100);
        clk1();
        chk("R12 sticky", 32'(stack_err), 1);
    endtask

    task automatic t_ignore();
        do_reset(2'b00);
        irq_entry = 1; rep_active = 1; clk1(); clk1(); idle();
        chk("R8 idle lf", 32'(sr_rdata), 32'h0300);
        start_loop(16'h0040, 16'h0044, 16'd5);
        irq_entry = 1; rep_active = 1;
        clk1(); clk1(); clk1(); idle();
        chk("R8 lf kept", 32'(sr_rdata), 32'h8300);
        chk("R8 nl kept", 32'(omr_rdata), 0);
        chk("R8 stack kept", 32'({hws_level, hws_top}), {2'd1, 16'h0040});
    endtask

    task automatic t_sr();
        do_reset(2'b00);
        sr_wr = 1; sr_wdata = 16'hFFFF; clk1(); idle();
        chk("R9 reserved zero", 32'(sr_rdata), 32'h83FF);
        chk("R11 code 11", 32'({ipl0_en, ipl1_en}), 32'b01);
        sr_wr = 1; sr_wdata = 16'h0100; clk1(); idle();
        chk("R9 lf cleared", 32'(sr_rdata), 32'h0100);
        chk("R11 code 01", 32'({ipl0_en, ipl1_en}), 32'b11);
        sr_wr = 1; sr_wdata = 16'h0200; clk1(); idle();
        chk("R11 code 10", 32'({ipl0_en, ipl1_en}), 0);
        sr_wr = 1; sr_wdata = 16'h0000; clk1(); idle();
        chk("R11 code 00", 32'({ipl0_en, ipl1_en}), 0);
    endtask

    task automatic t_omr();
        do_reset(2'b11);
        chk("R1 mode pins", 32'(omr_rdata), 32'h0003);
        omr_wr = 1; omr_wdata = 16'hFFFC; clk1(); idle();
        chk("R10 omr load", 32'(omr_rdata), 32'hFFFC);
        chk("R10 lf untouched", 32'(sr_rdata), 32'h0300);
        hws_rd = 1; clk1(); idle();
        chk("R7 nl into lf", 32'({sr_rdata[15], omr_rdata}), {1'b1, 16'h7FFC});
    endtask

    task automatic t_priority();
        do_reset(2'b00);
        do_start = 1; do_top = 16'h0200; do_end = 16'h0210; do_count = 16'd2;
        hws_wr = 1; hws_wdata = 16'hBEEF;
        sr_wr = 1; sr_wdata = 16'h0000;
        omr_wr = 1; omr_wdata = 16'hFFFF;
        clk1(); idle();
        chk("R13 do wins", 32'({hws_level, hws_top}), {2'd1, 16'h0200});
        chk("R13 sr ignored", 32'(sr_rdata), 32'h8300);
        chk("R13 omr ignored", 32'(omr_rdata), 0);
        fetch_vld = 1; fetch_addr = 16'h0210; sr_wr = 1; sr_wdata = 16'h0000;
        clk1(); idle();
        chk("R13 hit beats sr", 32'({loop_back, sr_rdata}), {1'b1, 16'h8300});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        t_reset();
        t_single_loop();
        t_nested();
        t_move_stack();
        t_ignore();
        t_sr();
        t_omr();
        t_priority();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule